// File: doc/BRIEF.md
# Battery-Backed Byte-Wide SRAM Controller

This block is a byte-wide static memory with active-low chip select, output enable and write enable, combined with a supply supervisor. Each cycle it turns the three control pins and two supply flags into one operating mode. That mode is a write, a read, or an idle bus. The two flags are "supply in tolerance" and "supply above the battery switchover level". Whenever the supply is not valid, writes are blocked and the data bus is released. This holds for every pin combination. The stored bytes are kept while the supply is invalid, and they can be read again once it returns.

Reads are registered. The addressed byte and its drive-enable flag appear one clock after the read is sampled. The drive-enable flag is also gated at once by the present supply state, so a supply drop releases the bus in the same cycle. A 2-bit power-mode output reports active, standby, low-power standby or battery backup, decoded combinationally from the inputs. The depth is 2**ADDR_W bytes; ADDR_W = 13 gives the 8192-byte array with 13 address lines.

Top module: `bbs_ctrl`

## Requirements
- R1: On a rising edge with the supply valid, chip select low and write enable low, the byte on din is stored at addr, whatever the output enable level (write enable wins over output enable).
- R2: On a rising edge with the supply valid, chip select low, output enable low and write enable high, dout shows the byte stored at addr and dout_en is 1, both from that edge until the next edge.
- R3: With chip select high and the supply valid, nothing is written, dout_en is 0 after the next edge and pwr_mode is 01 (standby), for any output enable and write enable level.
- R4: With chip select low, output enable high and write enable high, nothing is written, dout_en is 0 after the next edge and pwr_mode is 00 (active).
- R5: The supply is valid only when sup_ok and sup_above are both 1. While it is not valid, no write takes place, including at an edge where sup_ok has just fallen, and dout_en is 0 at once, within the same cycle, for every pin combination.
- R6: pwr_mode follows the inputs combinationally: 00 active (supply valid, chip select low), 01 standby (supply valid, chip select high), 10 low-power standby (sup_ok 0, sup_above 1), 11 battery backup (sup_above 0).
- R7: The inconsistent supply state (sup_ok 1, sup_above 0) is treated as not valid, so writes are blocked, the bus is off and pwr_mode is 11.
- R8: Bytes written before the supply became invalid read back unchanged once the supply is valid again, after any number of blocked writes in between.
- R9: While rst_n is low, dout_en is 0 and dout is 0; whenever dout_en is 0, dout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read path |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| sup_ok | input | 1 | Supply is within tolerance |
| sup_above | input | 1 | Supply is above the battery switchover level |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Data bus drive enable |
| pwr_mode | output | 2 | Power mode: 00 active, 01 standby, 10 low-power standby, 11 battery |

## Verification
A full write sweep followed by a full read sweep of every address uses distinct arithmetic data patterns. This separates address decoding faults from data path faults, and it also shows that write enable wins over output enable. An exhaustive sweep over all 32 combinations of the three control pins and the two supply flags checks the power mode and the bus enable. The same sweep tracks which combinations may write, so any write that should not happen is caught later on read-back. Blocked-write sweeps under both invalid supply states, and under the inconsistent one, are followed by a full read-back, which separates retention from write protection. Back-to-back cases cover a read right after a write to the same address and a supply drop in the cycle after a read.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'b00,
    PM_STANDBY = 2'b01,
    PM_LOWPWR  = 2'b10,
    PM_BATTERY = 2'b11
  } pwr_mode_t;

  // Supply counts as usable only when both flags agree that it is good.
  function automatic logic f_supply_valid(input logic ok, input logic above);
    return ok & above;
  endfunction

  function automatic pwr_mode_t f_pwr_mode(input logic ok, input logic above,
                                           input logic ce_n);
    pwr_mode_t m;
    if (!above)                        m = PM_BATTERY;
    else if (!ok)                      m = PM_LOWPWR;
    else if (ce_n)                     m = PM_STANDBY;
    else                               m = PM_ACTIVE;
    return m;
  endfunction

endpackage

// File: rtl/bbs_mode_decode.sv
module bbs_mode_decode
  import bbs_pkg::*;
(
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  input  logic      sup_ok,
  input  logic      sup_above,
  output logic      supply_valid,
  output logic      wr_event,
  output logic      rd_event,
  output pwr_mode_t mode
);

  always_comb begin
    supply_valid = f_supply_valid(sup_ok, sup_above);
    mode         = f_pwr_mode(sup_ok, sup_above, ce_n);
    // Write enable has priority over output enable.
    wr_event     = supply_valid & ~ce_n & ~we_n;
    rd_event     = supply_valid & ~ce_n & we_n & ~oe_n;
  end

  // R1: a write and a read never happen in the same cycle.
  always_comb begin
    p_wr_rd_exclusive_r1: assert (!(wr_event && rd_event));
  end

  // R5: no access is decoded without a valid supply.
  always_comb begin
    p_no_access_unpowered_r5: assert (supply_valid || !(wr_event || rd_event));
  end

endmodule

// File: rtl/bbs_array.sv
module bbs_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage is never reset so contents persist across supply loss.
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= mem[addr];
    end
  end

  // R2: a sampled read yields valid data exactly one edge later.
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  // R2: without a read, the valid flag is dropped after the edge.
  p_no_phantom_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

endmodule

// File: rtl/bbs_ctrl.sv
module bbs_ctrl
  import bbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              sup_ok,
  input  logic              sup_above,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [1:0]        pwr_mode
);

  logic              supply_valid;
  logic              wr_event;
  logic              rd_event;
  pwr_mode_t         mode;
  logic [DATA_W-1:0] rd_q;
  logic              rd_vld_q;

  bbs_mode_decode u_dec (
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .sup_ok       (sup_ok),
    .sup_above    (sup_above),
    .supply_valid (supply_valid),
    .wr_event     (wr_event),
    .rd_event     (rd_event),
    .mode         (mode)
  );

  bbs_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_event),
    .rd_en  (rd_event),
    .addr   (addr),
    .wdata  (din),
    .rdata  (rd_q),
    .rvalid (rd_vld_q)
  );

  // The present supply state gates the registered enable so a drop
  // releases the bus in the same cycle.
  assign dout_en  = rd_vld_q & supply_valid;
  assign dout     = dout_en ? rd_q : '0;
  assign pwr_mode = mode;

  // R5: the bus is never driven while the supply is not valid.
  p_bus_off_unpowered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sup_ok && sup_above) |-> !dout_en);

  // R5: a write is only decoded with both supply flags high.
  p_write_needs_power_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_event |-> (sup_ok && sup_above));

  // R3: a deselected cycle never produces driven data at the next edge.
  p_deselect_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dout_en);

  // R6: any access reports the active power mode.
  p_access_is_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_event || rd_event) |-> (pwr_mode == 2'b00));

  // R7: the inconsistent supply state reports battery mode.
  p_inconsistent_battery_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_ok && !sup_above) |-> (pwr_mode == 2'b11));

  // R9: undriven output data is zero.
  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));

endmodule

// File: tb/bbs_ctrl_test.sv
`timescale 1ns/1ps
module bbs_ctrl_test;

  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          sup_ok = 1'b1, sup_above = 1'b1;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic [1:0]    pwr_mode;

  int n_chk = 0;
  int n_bad = 0;
  logic          done = 1'b0;
  logic [DW-1:0] model [DEPTH];
  logic          prev_en = 1'b0;
  logic [DW-1:0] prev_dat = '0;

  bbs_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .sup_ok(sup_ok), .sup_above(sup_above),
    .dout(dout), .dout_en(dout_en), .pwr_mode(pwr_mode)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected power mode, worked out from the encoding table in R6.
  function automatic logic [1:0] exp_mode(input logic ok, input logic so, input logic ce);
    logic good;
    good = ok && so;
    return good ? {1'b0, ce} : (so ? 2'd2 : 2'd3);
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 37 + k * 11 + 5) ^ (a >> 3));
  endfunction

  // One bus cycle: drive at the falling edge, check the combinational
  // outputs, then check the registered outputs after the rising edge.
  task automatic cyc(input string tag, input logic ce, input logic oe, input logic we,
                     input int a, input logic [DW-1:0] d,
                     input logic ok, input logic so);
    logic good, rd, wr;
    logic [DW-1:0] rexp;
    @(negedge clk);
    ce_n = ce; oe_n = oe; we_n = we; addr = AW'(a); din = d;
    sup_ok = ok; sup_above = so;
    good = ok && so;
    rd   = good && !ce && !oe && we;
    wr   = good && !ce && !we;
    #1;
    check(tag, "pwr_mode", {30'd0, pwr_mode}, {30'd0, exp_mode(ok, so, ce)});
    check(tag, "dout_en now", {31'd0, dout_en}, {31'd0, prev_en && good});
    check(tag, "dout now", {24'd0, dout}, {24'd0, (prev_en && good) ? prev_dat : 8'd0});
    rexp = rd ? model[a] : '0;
    @(posedge clk);
    #1;
    if (wr) model[a] = d;
    check(tag, "dout_en", {31'd0, dout_en}, {31'd0, rd});
    check(tag, "dout", {24'd0, dout}, {24'd0, rexp});
    prev_en  = rd;
    prev_dat = rexp;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R9", "dout_en reset", {31'd0, dout_en}, 32'd0);
    check("R9", "dout reset", {24'd0, dout}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: fill every address, alternating output enable to show write priority
    for (int a = 0; a < DEPTH; a++) cyc("R1", 1'b0, a[0], 1'b0, a, pat(a, 0), 1'b1, 1'b1);
    // R2: read every address back
    for (int a = 0; a < DEPTH; a++) cyc("R2", 1'b0, 1'b0, 1'b1, a, 8'h00, 1'b1, 1'b1);

    // R1/R2: read right after a write to the same address
    cyc("R1", 1'b0, 1'b1, 1'b0, 3, 8'h5A, 1'b1, 1'b1);
    cyc("R2", 1'b0, 1'b0, 1'b1, 3, 8'h00, 1'b1, 1'b1);

    // R3 R4 R6: all pin and supply combinations; the model tracks which may write
    for (int c = 0; c < 32; c++)
      cyc("R6", c[0], c[1], c[2], (c * 7) % DEPTH, 8'(c) ^ 8'hA5, c[3], c[4]);
    // R4: active but idle bus
    cyc("R4", 1'b0, 1'b1, 1'b1, 9, 8'hFF, 1'b1, 1'b1);
    // R3: deselected write attempt
    cyc("R3", 1'b1, 1'b0, 1'b0, 9, 8'hC3, 1'b1, 1'b1);

    // R5: supply drops in the cycle after a read; bus released at once
    cyc("R5", 1'b0, 1'b0, 1'b1, 9, 8'h00, 1'b1, 1'b1);
    cyc("R5", 1'b0, 1'b0, 1'b0, 9, 8'h3C, 1'b0, 1'b1);

    // R5 R8: blocked writes over every address in both invalid states
    for (int a = 0; a < DEPTH; a++)
      cyc("R5", 1'b0, a[0], 1'b0, a, ~pat(a, 1), 1'b0, a[1]);
    // R7: inconsistent flags
    for (int a = 0; a < 16; a++)
      cyc("R7", 1'b0, 1'b1, 1'b0, a, pat(a, 2), 1'b1, 1'b0);

    // R8: supply restored, every byte must read back unchanged
    for (int a = 0; a < DEPTH; a++) cyc("R8", 1'b0, 1'b0, 1'b1, a, 8'h00, 1'b1, 1'b1);
    cyc("R9", 1'b1, 1'b1, 1'b1, 0, 8'h00, 1'b1, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule